// File: doc/BRIEF.md
# Debug Communications Mailbox

This block carries 32-bit words in both directions between a target processor and an external debugger. Each direction holds a single word with one "held" flag. The target reaches the block through a coprocessor-style register port: register 0 returns status and register 1 carries data. The debugger reaches it through a small register port with two addresses, which stands in for a serial scan access. Both ports share one clock.

A 6-bit status word shows both held flags, two sticky overflow bits and a fixed version field. The receive-waiting flag and the transmit-empty flag also leave the block as level outputs. An interrupt controller can use them instead of polling. A word sent into a direction that is still held is refused. The held word is kept and the overflow bit of that direction is set.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset both held flags and both overflow bits are 0, both data words are 0, `rx_full_irq` is 0 and `tx_empty_irq` is 1.
- R2: The status word is, from bit 0 upward: bit 0 RXH (debugger-to-target word held), bit 1 TXH (target-to-debugger word held), bit 2 RX overflow, bit 3 TX overflow, bits 5:4 version (parameter `VERSION`, default 1). It is returned zero-extended by target register 0 and by debugger address 0.
- R3: A target write to register 1 stores the word and sets TXH from the next cycle. A debugger read of address 1 returns the stored word and clears TXH from the next cycle.
- R4: A debugger write to address 1 stores the word and sets RXH from the next cycle. A target read of register 1 returns the stored word and clears RXH from the next cycle.
- R5: A write into a direction whose held flag is set, with no draining read of that direction in the same cycle, leaves the stored word unchanged. It sets that direction's overflow bit from the next cycle.
- R6: A write in the same cycle as the draining read of a held word is accepted. The flag stays set and the new word replaces the old one.
- R7: Overflow bits are sticky. A debugger write to address 0 clears bit 2 and/or bit 3 where the written value has a 1. A 0 leaves the bit alone. A new overflow in the same cycle wins over the clear.
- R8: Debugger writes to address 0 leave the held flags and the version field unchanged.
- R9: Target writes to any register other than 1 have no effect. Target reads of registers other than 0 and 1 return 0.
- R10: A read of an empty direction leaves all flags unchanged.
- R11: `rx_full_irq` equals RXH and `tx_empty_irq` equals the inverse of TXH in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| tgt_en | input | 1 | Target register access this cycle |
| tgt_wr | input | 1 | Target access is a write (1) or a read (0) |
| tgt_reg | input | TGT_RW | Target register number |
| tgt_wdata | input | DATA_W | Target write data |
| tgt_rdata | output | DATA_W | Target read data for `tgt_reg` |
| dbg_en | input | 1 | Debugger access this cycle |
| dbg_wr | input | 1 | Debugger access is a write (1) or a read (0) |
| dbg_addr | input | 1 | Debugger address: 0 status, 1 data |
| dbg_wdata | input | DATA_W | Debugger write data |
| dbg_rdata | output | DATA_W | Debugger read data for `dbg_addr` |
| rx_full_irq | output | 1 | Level: a debugger word waits for the target |
| tx_empty_irq | output | 1 | Level: the target may send a new word |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 4-bit target register number and version 1. With these widths, full 32-bit data patterns, the zero-extended status word and register numbers above 1 are all visible at the ports. Directed sequences walk each direction through fill, overflow, same-cycle refill and sticky-bit clearing. A long random mix then drives both ports at once. That mix brings simultaneous pushes, drains and clears within reach in many combinations.

// File: rtl/dbg_mailbox_pkg.sv
// Shared constants for the debug mailbox: status bit positions,
// register numbers and direction indices.
package dbg_mailbox_pkg;
    localparam int CTRL_W        = 6;
    localparam int BIT_RXH       = 0;
    localparam int BIT_TXH       = 1;
    localparam int BIT_OVF_RX    = 2;
    localparam int BIT_OVF_TX    = 3;
    localparam int VER_LSB       = 4;
    localparam int VER_W         = 2;
    localparam int TGT_REG_CTRL  = 0;
    localparam int TGT_REG_DATA  = 1;
    localparam logic DBG_A_CTRL  = 1'b0;
    localparam logic DBG_A_DATA  = 1'b1;
    localparam int DIR_RX        = 0;   // debugger -> target
    localparam int DIR_TX        = 1;   // target -> debugger
    localparam int NUM_DIR       = 2;
endpackage

// File: rtl/mbx_slot.sv
// One single-word mailbox direction. It holds a word and a held flag.
// A push is accepted when the slot is empty or is drained in the same
// cycle. A refused push sets a sticky overflow bit.
// Assumes the push and pop strobes last one cycle each.
module mbx_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] word,
    output logic              full,
    output logic              ovf
);
    logic accept;

    // Acceptance: the slot is empty, or its word leaves this cycle
    always_comb accept = push && (!full || pop);

    // Word storage and held flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            full <= 1'b0;
        end else begin
            if (accept) word <= push_data;
            if (accept)   full <= 1'b1;
            else if (pop) full <= 1'b0;
        end
    end

    // Sticky overflow: a refused push wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                ovf <= 1'b0;
        else if (push && !accept)  ovf <= 1'b1;
        else if (ovf_clr)          ovf <= 1'b0;
    end
endmodule

// File: rtl/mbx_access_dec.sv
// Decodes target and debugger port accesses into per-direction push,
// pop and overflow-clear strobes. It has no state.
module mbx_access_dec
    import dbg_mailbox_pkg::*;
#(
    parameter int TGT_RW = 4
) (
    input  logic              tgt_en,
    input  logic              tgt_wr,
    input  logic [TGT_RW-1:0] tgt_reg,
    input  logic              dbg_en,
    input  logic              dbg_wr,
    input  logic              dbg_addr,
    input  logic [1:0]        clr_req,   // written bits {ovf_tx, ovf_rx}
    output logic [NUM_DIR-1:0] push,
    output logic [NUM_DIR-1:0] pop,
    output logic [NUM_DIR-1:0] ovf_clr
);
    logic tgt_data, dbg_data, dbg_ctrl_wr;

    // Address match for each port
    always_comb begin
        tgt_data    = tgt_en && (tgt_reg == TGT_RW'(TGT_REG_DATA));
        dbg_data    = dbg_en && (dbg_addr == DBG_A_DATA);
        dbg_ctrl_wr = dbg_en && dbg_wr && (dbg_addr == DBG_A_CTRL);
    end

    // Strobes for each direction
    always_comb begin
        push[DIR_TX]    = tgt_data && tgt_wr;
        pop[DIR_RX]     = tgt_data && !tgt_wr;
        push[DIR_RX]    = dbg_data && dbg_wr;
        pop[DIR_TX]     = dbg_data && !dbg_wr;
        ovf_clr[DIR_RX] = dbg_ctrl_wr && clr_req[0];
        ovf_clr[DIR_TX] = dbg_ctrl_wr && clr_req[1];
    end
endmodule

// File: rtl/mbx_read_mux.sv
// Builds the status word and the read data of both ports from the slot
// state. It has no state.
module mbx_read_mux
    import dbg_mailbox_pkg::*;
#(
    parameter int         DATA_W  = 32,
    parameter int         TGT_RW  = 4,
    parameter logic [1:0] VERSION = 2'd1
) (
    input  logic [NUM_DIR-1:0] full,
    input  logic [NUM_DIR-1:0] ovf,
    input  logic [DATA_W-1:0]  rx_word,
    input  logic [DATA_W-1:0]  tx_word,
    input  logic [TGT_RW-1:0]  tgt_reg,
    input  logic               dbg_addr,
    output logic [CTRL_W-1:0]  ctrl_word,
    output logic [DATA_W-1:0]  tgt_rdata,
    output logic [DATA_W-1:0]  dbg_rdata
);
    // Status word assembly
    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[BIT_RXH]                 = full[DIR_RX];
        ctrl_word[BIT_TXH]                 = full[DIR_TX];
        ctrl_word[BIT_OVF_RX]              = ovf[DIR_RX];
        ctrl_word[BIT_OVF_TX]              = ovf[DIR_TX];
        ctrl_word[VER_LSB +: VER_W]        = VERSION;
    end

    // Target read data
    always_comb begin
        if (tgt_reg == TGT_RW'(TGT_REG_CTRL))      tgt_rdata = DATA_W'(ctrl_word);
        else if (tgt_reg == TGT_RW'(TGT_REG_DATA)) tgt_rdata = rx_word;
        else                                       tgt_rdata = '0;
    end

    // Debugger read data
    always_comb dbg_rdata = (dbg_addr == DBG_A_DATA) ? tx_word : DATA_W'(ctrl_word);
endmodule

// File: rtl/dbg_mailbox.sv
// Two-direction single-word debug mailbox with level interrupt flags.
// Assumes both ports share clk, and that an access lasts one cycle.
module dbg_mailbox
    import dbg_mailbox_pkg::*;
#(
    parameter int         DATA_W  = 32,
    parameter int         TGT_RW  = 4,
    parameter logic [1:0] VERSION = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_en,
    input  logic              tgt_wr,
    input  logic [TGT_RW-1:0] tgt_reg,
    input  logic [DATA_W-1:0] tgt_wdata,
    output logic [DATA_W-1:0] tgt_rdata,
    input  logic              dbg_en,
    input  logic              dbg_wr,
    input  logic              dbg_addr,
    input  logic [DATA_W-1:0] dbg_wdata,
    output logic [DATA_W-1:0] dbg_rdata,
    output logic              rx_full_irq,
    output logic              tx_empty_irq
);
    logic [NUM_DIR-1:0] push, pop, ovf_clr, full, ovf;
    logic [DATA_W-1:0]  slot_word [NUM_DIR];
    logic [CTRL_W-1:0]  ctrl_word;

    mbx_access_dec #(.TGT_RW(TGT_RW)) u_dec (
        .tgt_en  (tgt_en),
        .tgt_wr  (tgt_wr),
        .tgt_reg (tgt_reg),
        .dbg_en  (dbg_en),
        .dbg_wr  (dbg_wr),
        .dbg_addr(dbg_addr),
        .clr_req (dbg_wdata[BIT_OVF_TX:BIT_OVF_RX]),
        .push    (push),
        .pop     (pop),
        .ovf_clr (ovf_clr)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        logic [DATA_W-1:0] wdata;
        // Each direction takes its data from the port that fills it
        if (d == DIR_RX) begin : g_rx
            always_comb wdata = dbg_wdata;
        end else begin : g_tx
            always_comb wdata = tgt_wdata;
        end
        mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push[d]),
            .push_data(wdata),
            .pop      (pop[d]),
            .ovf_clr  (ovf_clr[d]),
            .word     (slot_word[d]),
            .full     (full[d]),
            .ovf      (ovf[d])
        );
    end

    mbx_read_mux #(.DATA_W(DATA_W), .TGT_RW(TGT_RW), .VERSION(VERSION)) u_mux (
        .full     (full),
        .ovf      (ovf),
        .rx_word  (slot_word[DIR_RX]),
        .tx_word  (slot_word[DIR_TX]),
        .tgt_reg  (tgt_reg),
        .dbg_addr (dbg_addr),
        .ctrl_word(ctrl_word),
        .tgt_rdata(tgt_rdata),
        .dbg_rdata(dbg_rdata)
    );

    // Level flags for the interrupt controller
    always_comb begin
        rx_full_irq  = full[DIR_RX];
        tx_empty_irq = !full[DIR_TX];
    end
endmodule

// File: rtl/dbg_mailbox_chk.sv
// Checker for dbg_mailbox. It relates the port strobes to the flags and
// held words one cycle later. It is attached by bind.
module dbg_mailbox_chk
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TGT_RW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tgt_en,
    input logic              tgt_wr,
    input logic [TGT_RW-1:0] tgt_reg,
    input logic              dbg_en,
    input logic              dbg_wr,
    input logic              dbg_addr,
    input logic              dbg_clr_rx,
    input logic              rx_full_irq,
    input logic              tx_empty_irq,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic [DATA_W-1:0] tx_word
);
    logic t_push, d_drain, d_push, d_clr_rx;

    // Port strobes seen from outside the decoder
    always_comb begin
        t_push   = tgt_en && tgt_wr && (tgt_reg == TGT_RW'(TGT_REG_DATA));
        d_drain  = dbg_en && !dbg_wr && dbg_addr;
        d_push   = dbg_en && dbg_wr && dbg_addr;
        d_clr_rx = dbg_en && dbg_wr && !dbg_addr && dbg_clr_rx;
    end

    AST_TX_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        t_push |=> !tx_empty_irq); // R3
    AST_TX_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (d_drain && !t_push) |=> tx_empty_irq); // R3
    AST_RX_PUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        d_push |=> rx_full_irq); // R4
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty_irq && t_push && !d_drain) |=> ($stable(tx_word) && ctrl_word[BIT_OVF_TX])); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[BIT_OVF_RX] && !d_clr_rx) |=> ctrl_word[BIT_OVF_RX]); // R7
    AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_irq == ctrl_word[BIT_RXH]) && (tx_empty_irq == !ctrl_word[BIT_TXH])); // R11
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W), .TGT_RW(TGT_RW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_en      (tgt_en),
    .tgt_wr      (tgt_wr),
    .tgt_reg     (tgt_reg),
    .dbg_en      (dbg_en),
    .dbg_wr      (dbg_wr),
    .dbg_addr    (dbg_addr),
    .dbg_clr_rx  (dbg_wdata[2]),
    .rx_full_irq (rx_full_irq),
    .tx_empty_irq(tx_empty_irq),
    .ctrl_word   (ctrl_word),
    .tx_word     (slot_word[1])
);

// File: tb/dbg_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_mailbox_tb;
    localparam int DW = 32;
    localparam int RW = 4;
    localparam logic [1:0] VER = 2'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tgt_en = 0, tgt_wr = 0, dbg_en = 0, dbg_wr = 0, dbg_addr = 0;
    logic [RW-1:0] tgt_reg = '0;
    logic [DW-1:0] tgt_wdata = '0, dbg_wdata = '0;
    logic [DW-1:0] tgt_rdata, dbg_rdata;
    logic          rx_full_irq, tx_empty_irq;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Behavioural reference state
    bit [31:0] m_rx_word, m_tx_word;
    bit        m_rx_full, m_tx_full, m_ovf_rx, m_ovf_tx;

    always #2.5 clk = ~clk;

    dbg_mailbox #(.DATA_W(DW), .TGT_RW(RW), .VERSION(VER)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .tgt_en(tgt_en), .tgt_wr(tgt_wr), .tgt_reg(tgt_reg),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .dbg_en(dbg_en), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .rx_full_irq(rx_full_irq), .tx_empty_irq(tx_empty_irq)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] m_status();
        return {26'd0, VER, m_ovf_tx, m_ovf_rx, m_tx_full, m_rx_full};
    endfunction

    // One cycle: drive, compare outputs, clock the reference model
    task automatic step(input string tag,
                        input bit te, input bit tw, input int tr, input bit [31:0] twd,
                        input bit de, input bit dw, input bit da, input bit [31:0] dwd);
        bit [31:0] exp_t, exp_d;
        bit t_push, t_pop, d_push, d_pop, d_ctrl;
        tgt_en = te; tgt_wr = tw; tgt_reg = RW'(tr); tgt_wdata = twd;
        dbg_en = de; dbg_wr = dw; dbg_addr = da; dbg_wdata = dwd;
        #1;
        exp_t = (tr == 0) ? m_status() : (tr == 1) ? m_rx_word : 32'd0;
        exp_d = da ? m_tx_word : m_status();
        check(tag, "tgt_rdata", tgt_rdata, exp_t);
        check(tag, "dbg_rdata", dbg_rdata, exp_d);
        check(tag, "rx_full_irq", 32'(rx_full_irq), 32'(m_rx_full));
        check(tag, "tx_empty_irq", 32'(tx_empty_irq), 32'(!m_tx_full));
        @(posedge clk);
        t_push = te && tw && tr == 1;  t_pop = te && !tw && tr == 1;
        d_push = de && dw && da;       d_pop = de && !dw && da;
        d_ctrl = de && dw && !da;
        if (d_ctrl && dwd[2]) m_ovf_rx = 0;
        if (d_ctrl && dwd[3]) m_ovf_tx = 0;
        if (d_push) begin
            if (!m_rx_full || t_pop) begin m_rx_word = dwd; m_rx_full = 1; end
            else m_ovf_rx = 1;
        end else if (t_pop) m_rx_full = 0;
        if (t_push) begin
            if (!m_tx_full || d_pop) begin m_tx_word = twd; m_tx_full = 1; end
            else m_ovf_tx = 1;
        end else if (d_pop) m_tx_full = 0;
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        m_rx_word = 0; m_tx_word = 0;
        m_rx_full = 0; m_tx_full = 0; m_ovf_rx = 0; m_ovf_tx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state; R2 status layout and version
        idle("R1");
        step("R2", 0, 0, 0, 0, 0, 0, 1, 0);
        // R3 target to debugger
        step("R3", 1, 1, 1, 32'hA5A5_0001, 0, 0, 1, 0);
        idle("R11");
        step("R3", 0, 0, 0, 0, 1, 0, 1, 0);
        idle("R3");
        // R4 debugger to target
        step("R4", 0, 0, 1, 0, 1, 1, 1, 32'h1234_5678);
        idle("R11");
        step("R4", 1, 0, 1, 0, 0, 0, 0, 0);
        idle("R4");
        // R5 overflow on both directions
        step("R5", 0, 0, 0, 0, 1, 1, 1, 32'h0000_00AA);
        step("R5", 0, 0, 0, 0, 1, 1, 1, 32'h0000_00BB);
        step("R5", 1, 0, 1, 0, 0, 0, 0, 0);
        step("R5", 1, 1, 1, 32'hCAFE_0001, 0, 0, 1, 0);
        step("R5", 1, 1, 1, 32'hCAFE_0002, 0, 0, 1, 0);
        // R6 refill in the draining cycle
        step("R6", 1, 1, 1, 32'hCAFE_0003, 1, 0, 1, 0);
        step("R6", 0, 0, 0, 0, 1, 0, 1, 0);
        // R7 and R8 status writes
        step("R7", 1, 1, 1, 32'h0000_0011, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 1, 1, 0, 32'h0);
        step("R8", 0, 0, 0, 0, 1, 1, 0, 32'hFFFF_FFF3);
        step("R7", 0, 0, 0, 0, 1, 1, 0, 32'h4);
        step("R7", 1, 1, 1, 32'h22, 1, 1, 0, 32'h8);
        idle("R7");
        step("R7", 0, 0, 0, 0, 1, 1, 0, 32'h8);
        idle("R8");
        // R9 other target registers
        step("R9", 1, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R9", 1, 1, 5, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R9", 1, 0, 7, 0, 0, 0, 0, 0);
        // R10 reads of empty directions
        step("R10", 0, 0, 0, 0, 1, 0, 1, 0);
        step("R10", 0, 0, 0, 0, 1, 0, 1, 0);
        step("R10", 1, 0, 1, 0, 0, 0, 0, 0);
        step("R10", 1, 0, 1, 0, 0, 0, 0, 0);
        idle("R10");
        // Mixed traffic on both ports
        for (int i = 0; i < 2000; i++) begin
            step("R6", 1'($urandom), 1'($urandom), int'($urandom % 3), $urandom,
                 1'($urandom), 1'($urandom), 1'($urandom), $urandom);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule